// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an 8-bit parallel NOR flash. It takes one request at a time from a valid/ready user port. A request names an operation (byte program, sector erase or chip erase), a target address and a data byte. The block then runs the whole job on the flash pins. First it writes the unlock and command cycles. Each of these writes is strobed by a chip-enable pulse while write-enable is held low for the whole sequence. After that it keeps reading the target location until the status shows the internal operation has finished.

All bus timing is set by cycle-count parameters: setup before the strobe, strobe width, hold and recovery after it, read access time and the gap between reads. These are chosen from the system clock period. Status polling compares bit 7 of each read with the value that is expected once the operation is complete. When a read does not match and bit 5 reports a time-limit fault, the block reads once more to make the final decision. A poll counter stops the job if the flash never finishes. The result comes back as a one-cycle done pulse with two error flags.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, flash_ce_n, flash_oe_n and flash_we_n are 1, flash_dq_oe is 0 and done is 0.
- R2: The op encoding is 2'b00 = byte program, 2'b01 = sector erase, and any value with bit 1 set = chip erase. A program issues exactly four writes (address/data): 555h/AAh, 2AAh/55h, 555h/A0h, then target/request data.
- R3: A sector erase issues exactly six writes: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then target/30h.
- R4: A chip erase issues the same first five writes as a sector erase, then 555h/10h.
- R5: Each write is a CE#-strobed cycle. CE# stays low for exactly T_CP clocks. CE# is high for at least T_CPH clocks before every write strobe. Address and driven data stay stable while CE# is low. WE# stays low from the first write to the last and rises exactly once per operation. OE# and WE# are never low together, and the data bus is driven only while OE# is high.
- R6: After the last write, the block reads the target address with CE# and OE# low and WE# high. It repeats these reads until DQ7 equals the expected bit: request data bit 7 for a program, 1 for an erase. It then pulses done with both error flags 0.
- R7: If a polled read mismatches on DQ7 with DQ5 = 1, exactly one more read follows. If that read matches, the operation ends without error. If it mismatches, done comes with err_timeout = 1.
- R8: If POLL_LIMIT polled reads all mismatch, the operation ends after the last of them with err_watchdog = 1. This check is made before the DQ5 check.
- R9: req_ready is 0 from the cycle after a request is accepted until done. A request held valid during that time starts nothing.
- R10: done is a one-cycle pulse. err_timeout and err_watchdog are only ever 1 together with done, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation code (see R2) |
| req_addr | input | AW | Target byte address / sector address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Device reported time-limit fault (with done) |
| err_watchdog | output | 1 | Poll limit reached (with done) |
| flash_addr | output | AW | Flash address bus |
| flash_dq_out | output | 8 | Data driven to the flash |
| flash_dq_oe | output | 1 | Enable for the data bus driver |
| flash_dq_in | input | 8 | Data read from the flash |
| flash_ce_n | output | 1 | Chip enable, active low (write strobe) |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
The assertions check the pin-level rules of R5 on every cycle: strobe width, stable address and data under a low CE#, OE#/WE# exclusion and bus-drive direction. They also check the handshake and flag rules of R9 and R10. Only the bench scenarios can show the command byte order of R2 to R4 and how many polled reads are made. The completion decisions of R6 to R8 also depend on a flash model that holds off completion for a chosen number of reads, raises DQ5, or never finishes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        K_PROG   = 2'd0,
        K_SERASE = 2'd1,
        K_CERASE = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSET,
        PH_WSTB,
        PH_WHLD,
        PH_RACC,
        PH_RGAP
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_POLL,
        SQ_RECHK
    } seq_e;

    typedef struct packed {
        logic        use_tgt_addr;
        logic        use_tgt_data;
        logic [11:0] addr;
        logic [7:0]  data;
    } cmd_word_t;

    function automatic cmd_word_t cmd_word(input kind_e kind, input logic [2:0] idx);
        cmd_word_t w;
        w = '{use_tgt_addr: 1'b0, use_tgt_data: 1'b0, addr: 12'h555, data: 8'hAA};
        case (idx)
            3'd1: begin w.addr = 12'h2AA; w.data = 8'h55; end
            3'd2: w.data = (kind == K_PROG) ? 8'hA0 : 8'h80;
            3'd3: begin
                if (kind == K_PROG) begin
                    w.use_tgt_addr = 1'b1;
                    w.use_tgt_data = 1'b1;
                end
            end
            3'd4: begin w.addr = 12'h2AA; w.data = 8'h55; end
            3'd5: begin
                if (kind == K_SERASE) begin
                    w.use_tgt_addr = 1'b1;
                    w.data = 8'h30;
                end else begin
                    w.data = 8'h10;
                end
            end
            default: ;
        endcase
        return w;
    endfunction

    function automatic int tmax5(input int a, input int b, input int c, input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/nor_status_eval.sv
module nor_status_eval (
    input  logic dq7,
    input  logic dq5,
    input  logic exp7,
    output logic match,
    output logic over_time
);
    always_comb begin
        match     = (dq7 == exp7);
        over_time = dq5;
    end
endmodule

// File: rtl/nor_bus_phy.sv
module nor_bus_phy
    import nor_seq_pkg::*;
#(
    parameter int AW      = 17,
    parameter int T_SETUP = 2,
    parameter int T_CP    = 7,
    parameter int T_CPH   = 4,
    parameter int T_RD    = 18,
    parameter int T_GAP   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_read,
    input  logic [AW-1:0] addr_in,
    input  logic [7:0]    data_in,
    input  logic          we_keep,
    output logic          fin,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dq_out,
    output logic          flash_dq_oe,
    input  logic [7:0]    flash_dq_in,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic          flash_we_n
);
    localparam int TM = tmax5(T_SETUP, T_CP, T_CPH, T_RD, T_GAP);
    localparam int CW = $clog2(TM + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    rd;
        logic          fin;
    } phy_t;

    phy_t r_q, r_d;
    logic wr_ph;

    always_comb begin
        r_d     = r_q;
        r_d.fin = 1'b0;
        case (r_q.ph)
            PH_IDLE: if (start) begin
                r_d.addr = addr_in;
                r_d.data = data_in;
                r_d.ph   = is_read ? PH_RACC : PH_WSET;
                r_d.cnt  = is_read ? CW'(T_RD - 1) : CW'(T_SETUP - 1);
            end
            PH_WSET: if (r_q.cnt == '0) begin
                r_d.ph  = PH_WSTB;
                r_d.cnt = CW'(T_CP - 1);
            end else r_d.cnt = r_q.cnt - 1'b1;
            PH_WSTB: if (r_q.cnt == '0) begin
                r_d.ph  = PH_WHLD;
                r_d.cnt = CW'(T_CPH - 1);
            end else r_d.cnt = r_q.cnt - 1'b1;
            PH_WHLD: if (r_q.cnt == '0) begin
                r_d.ph  = PH_IDLE;
                r_d.fin = 1'b1;
            end else r_d.cnt = r_q.cnt - 1'b1;
            PH_RACC: if (r_q.cnt == '0) begin
                r_d.rd  = flash_dq_in;
                r_d.ph  = PH_RGAP;
                r_d.cnt = CW'(T_GAP - 1);
            end else r_d.cnt = r_q.cnt - 1'b1;
            PH_RGAP: if (r_q.cnt == '0) begin
                r_d.ph  = PH_IDLE;
                r_d.fin = 1'b1;
            end else r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, data: '0, rd: '0, fin: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        wr_ph        = (r_q.ph == PH_WSET) || (r_q.ph == PH_WSTB) || (r_q.ph == PH_WHLD);
        flash_ce_n   = !((r_q.ph == PH_WSTB) || (r_q.ph == PH_RACC));
        flash_oe_n   = !(r_q.ph == PH_RACC);
        flash_we_n   = !(wr_ph || we_keep);
        flash_dq_oe  = wr_ph;
        flash_addr   = r_q.addr;
        flash_dq_out = r_q.data;
        fin          = r_q.fin;
        rd_data      = r_q.rd;
    end

    // strobe-width observer for the checks below
    logic [CW:0] ce_lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           ce_lo_q <= '0;
        else if (!flash_ce_n) ce_lo_q <= ce_lo_q + 1'b1;
        else                  ce_lo_q <= '0;
    end

    p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flash_ce_n) && !flash_we_n) |-> (ce_lo_q == (CW+1)'(T_CP)));
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr));
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && flash_dq_oe && $past(!flash_ce_n)) |-> $stable(flash_dq_out));
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_oe_n && !flash_we_n));
    p_drive_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flash_dq_oe |-> flash_oe_n);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW         = 17,
    parameter int T_SETUP    = 2,
    parameter int T_CP       = 7,
    parameter int T_CPH      = 4,
    parameter int T_RD       = 18,
    parameter int T_GAP      = 4,
    parameter int POLL_LIMIT = 100000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          err_timeout,
    output logic          err_watchdog,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dq_out,
    output logic          flash_dq_oe,
    input  logic [7:0]    flash_dq_in,
    output logic          flash_ce_n,
    output logic          flash_oe_n,
    output logic          flash_we_n
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        seq_e          st;
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [2:0]    idx;
        logic [PW-1:0] polls;
        logic          pend;
        logic          we_keep;
        logic          done;
        logic          err_to;
        logic          err_wd;
    } seq_t;

    seq_t r_q, r_d;
    cmd_word_t cw;
    logic start, is_read, fin, match, over_time, exp7;
    logic [AW-1:0] phy_addr;
    logic [7:0] phy_data, rd_data;
    logic [2:0] last_idx;

    always_comb begin
        exp7     = (r_q.kind == K_PROG) ? r_q.data[7] : 1'b1;
        last_idx = (r_q.kind == K_PROG) ? 3'd3 : 3'd5;
        cw       = cmd_word(r_q.kind, r_q.idx);
    end

    nor_status_eval u_eval (
        .dq7(rd_data[7]), .dq5(rd_data[5]), .exp7(exp7),
        .match(match), .over_time(over_time)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.err_to = 1'b0;
        r_d.err_wd = 1'b0;
        start      = 1'b0;
        is_read    = 1'b0;
        phy_addr   = r_q.addr;
        phy_data   = r_q.data;
        case (r_q.st)
            SQ_IDLE: if (req_valid) begin
                r_d.kind  = req_op[1] ? K_CERASE : (req_op[0] ? K_SERASE : K_PROG);
                r_d.addr  = req_addr;
                r_d.data  = req_data;
                r_d.idx   = '0;
                r_d.polls = '0;
                r_d.pend  = 1'b0;
                r_d.st    = SQ_CMD;
            end
            SQ_CMD: begin
                phy_addr = cw.use_tgt_addr ? r_q.addr : AW'(cw.addr);
                phy_data = cw.use_tgt_data ? r_q.data : cw.data;
                if (!r_q.pend) begin
                    start    = 1'b1;
                    r_d.pend = 1'b1;
                end else if (fin) begin
                    r_d.pend = 1'b0;
                    if (r_q.idx == last_idx) r_d.st = SQ_POLL;
                    else r_d.idx = r_q.idx + 1'b1;
                end
            end
            SQ_POLL: begin
                is_read = 1'b1;
                if (!r_q.pend) begin
                    start    = 1'b1;
                    r_d.pend = 1'b1;
                end else if (fin) begin
                    r_d.pend = 1'b0;
                    if (match) begin
                        r_d.st   = SQ_IDLE;
                        r_d.done = 1'b1;
                    end else if (r_q.polls == PW'(POLL_LIMIT - 1)) begin
                        r_d.st     = SQ_IDLE;
                        r_d.done   = 1'b1;
                        r_d.err_wd = 1'b1;
                    end else begin
                        r_d.polls = r_q.polls + 1'b1;
                        if (over_time) r_d.st = SQ_RECHK;
                    end
                end
            end
            SQ_RECHK: begin
                is_read = 1'b1;
                if (!r_q.pend) begin
                    start    = 1'b1;
                    r_d.pend = 1'b1;
                end else if (fin) begin
                    r_d.pend   = 1'b0;
                    r_d.st     = SQ_IDLE;
                    r_d.done   = 1'b1;
                    r_d.err_to = !match;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
        r_d.we_keep = (r_d.st == SQ_CMD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SQ_IDLE, kind: K_PROG, addr: '0, data: '0, idx: '0, polls: '0,
                     pend: 1'b0, we_keep: 1'b0, done: 1'b0, err_to: 1'b0, err_wd: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    nor_bus_phy #(
        .AW(AW), .T_SETUP(T_SETUP), .T_CP(T_CP), .T_CPH(T_CPH), .T_RD(T_RD), .T_GAP(T_GAP)
    ) u_phy (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .addr_in(phy_addr), .data_in(phy_data), .we_keep(r_q.we_keep),
        .fin(fin), .rd_data(rd_data),
        .flash_addr(flash_addr), .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe),
        .flash_dq_in(flash_dq_in), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .flash_we_n(flash_we_n)
    );

    always_comb begin
        req_ready    = (r_q.st == SQ_IDLE);
        done         = r_q.done;
        err_timeout  = r_q.err_to;
        err_watchdog = r_q.err_wd;
    end

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout || err_watchdog) |-> done);
    p_single_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_timeout, err_watchdog}));
    p_no_ce_while_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !done) |-> flash_ce_n);
endmodule

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
    localparam int AW = 17;
    localparam int TCP = 3;
    localparam int TCPH = 2;
    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic req_ready, done, err_timeout, err_watchdog;
    logic [AW-1:0] flash_addr;
    logic [7:0] flash_dq_out, flash_dq_in;
    logic flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nor_cmd_seq #(.AW(AW), .T_SETUP(2), .T_CP(TCP), .T_CPH(TCPH), .T_RD(2), .T_GAP(1),
                  .POLL_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
        .err_timeout(err_timeout), .err_watchdog(err_watchdog), .flash_addr(flash_addr),
        .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in),
        .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
    );

    // flash model state
    int cur_kind = 0, cur_nb = 0, cur_md = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [7:0] cur_data = '0;
    int wn = 0, rn = 0, rd_bad = 0, we_rises = 0, tim_bad = 0;
    logic [AW-1:0] wa [0:7];
    logic [7:0] wdat [0:7];
    logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [7:0] l_data = '0;
    int lo_len = 0, hi_len = 100;

    function automatic logic [7:0] model_dq(int k, int nb, int md, logic [7:0] d, int r);
        logic [7:0] tv;
        tv = (k == 0) ? d : 8'hFF;
        if (r <= nb) return {~tv[7], 7'b0};
        if (md == 0 || (md == 1 && r > nb + 1)) return tv;
        return {~tv[7], 1'b0, 1'b1, 5'b0};
    endfunction

    assign flash_dq_in = model_dq(cur_kind, cur_nb, cur_md, cur_data, rn + 1);

    always @(negedge clk) begin
        if (!flash_ce_n) begin
            lo_len = lo_len + 1;
            l_addr = flash_addr;
            l_data = flash_dq_out;
            if (p_ce && !flash_we_n && hi_len < TCPH) tim_bad = tim_bad + 1;
            if (!p_ce && (flash_addr != l_addr)) tim_bad = tim_bad + 1;
        end
        if (flash_ce_n && !p_ce) begin
            if (!p_we) begin
                if (wn < 8) begin wa[wn] = l_addr; wdat[wn] = l_data; end
                wn = wn + 1;
                if (lo_len != TCP) tim_bad = tim_bad + 1;
            end
            if (!p_oe) begin
                rn = rn + 1;
                if (l_addr != cur_addr || !p_we) rd_bad = rd_bad + 1;
            end
        end
        if (flash_ce_n) begin
            hi_len = hi_len + 1;
            lo_len = 0;
        end else hi_len = 0;
        if (flash_we_n && !p_we) we_rises = we_rises + 1;
        if (!flash_we_n && !flash_oe_n) tim_bad = tim_bad + 1;
        p_ce = flash_ce_n;
        p_we = flash_we_n;
        p_oe = flash_oe_n;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW+7:0] exp_wr(int k, int i, logic [AW-1:0] a, logic [7:0] d);
        case (i)
            0: return {AW'(12'h555), 8'hAA};
            1: return {AW'(12'h2AA), 8'h55};
            2: return {AW'(12'h555), (k == 0) ? 8'hA0 : 8'h80};
            3: return (k == 0) ? {a, d} : {AW'(12'h555), 8'hAA};
            4: return {AW'(12'h2AA), 8'h55};
            default: return (k == 1) ? {a, 8'h30} : {AW'(12'h555), 8'h10};
        endcase
    endfunction

    // result code: 0 ok, 1 timeout, 2 watchdog; returns expected read count via ref
    function automatic int exp_res(int nb, int md, output int reads);
        if (nb >= LIM) begin reads = LIM; return 2; end
        if (md == 0) begin reads = nb + 1; return 0; end
        if (nb + 1 == LIM) begin reads = LIM; return 2; end
        reads = nb + 2;
        return (md == 1) ? 0 : 1;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                          input int nb, input int md, input bit probe);
        int k, nw, er, ereads, guard;
        logic [AW+7:0] ew;
        logic got_to, got_wd;
        string rq;
        k = op[1] ? 2 : (op[0] ? 1 : 0);
        nw = (k == 0) ? 4 : 6;
        rq = (k == 0) ? "R2" : ((k == 1) ? "R3" : "R4");
        er = exp_res(nb, md, ereads);
        @(negedge clk);
        cur_kind = k; cur_nb = nb; cur_md = md; cur_addr = a; cur_data = d;
        wn = 0; rn = 0; rd_bad = 0; we_rises = 0; tim_bad = 0;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        chk(req_ready == 1'b0, "R9", "ready low after accept", int'(req_ready), 0);
        if (probe) begin
            req_op = 2'b10; req_addr = '1;
            repeat (30) @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        got_to = err_timeout; got_wd = err_watchdog;
        chk(done == 1'b1, "R10", "done seen", int'(done), 1);
        chk(wn == nw, rq, "write count", wn, nw);
        for (int i = 0; i < nw && i < wn && i < 8; i++) begin
            ew = exp_wr(k, i, a, d);
            chk({wa[i], wdat[i]} == ew, rq, "write cycle", int'({wa[i], wdat[i]}), int'(ew));
        end
        chk(tim_bad == 0 && we_rises == 1, "R5", "strobe timing / WE# rises", tim_bad * 100 + we_rises, 1);
        chk(rd_bad == 0, "R6", "poll reads at target with WE# high", rd_bad, 0);
        chk(rn == ereads, (er == 2) ? "R8" : ((md != 0) ? "R7" : "R6"), "poll read count", rn, ereads);
        chk(got_to == (er == 1), "R7", "err_timeout", int'(got_to), int'(er == 1));
        chk(got_wd == (er == 2), "R8", "err_watchdog", int'(got_wd), int'(er == 2));
        @(negedge clk);
        chk(done == 1'b0 && err_timeout == 1'b0 && err_watchdog == 1'b0, "R10", "done is one pulse",
            int'({done, err_timeout, err_watchdog}), 0);
        chk(req_ready == 1'b1, "R9", "ready back after done", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready && flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe && !done, "R1",
            "reset pin state", int'({req_ready, flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe, done}), 6'h3C);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe && !done, "R1",
            "post-reset pin state", int'({req_ready, flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe, done}), 6'h3C);
        // directed corners
        run_op(2'b00, 17'h1ABCD, 8'h5A, 0, 0, 1'b0);       // R2, R6 immediate finish
        run_op(2'b00, 17'h00010, 8'hC3, 3, 0, 1'b1);       // R2 bit7=1, R9 probe
        run_op(2'b01, 17'h0E000, 8'h00, 2, 0, 1'b0);       // R3
        run_op(2'b10, 17'h00000, 8'h00, 1, 0, 1'b0);       // R4
        run_op(2'b11, 17'h12345, 8'h00, 0, 0, 1'b0);       // R4 alias encoding
        run_op(2'b00, 17'h00777, 8'h81, 2, 1, 1'b0);       // R7 recovers
        run_op(2'b01, 17'h04000, 8'h00, 1, 2, 1'b0);       // R7 timeout
        run_op(2'b00, 17'h00042, 8'h11, LIM + 3, 0, 1'b0); // R8 never finishes
        run_op(2'b10, 17'h00000, 8'h00, LIM - 1, 2, 1'b0); // R8 wins over DQ5
        run_op(2'b00, 17'h00042, 8'h11, LIM - 1, 0, 1'b0); // R6 match on last allowed read
        for (int n = 0; n < 24; n++) begin
            run_op(2'($urandom_range(3)), AW'($urandom), 8'($urandom),
                   int'($urandom_range(5)), int'($urandom_range(2)), 1'($urandom_range(1)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule